// File: doc/BRIEF.md
# S/PDIF Channel Status Capture Buffer

This block gathers the channel status bits of a received IEC60958 stream into a 192-bit block that a host reads one byte at a time. A decoder upstream presents one beat per received subframe. Each beat carries a two-bit subframe type code and the subframe's channel status bit. Only subframes of the first channel contribute. A block starts at the subframe marked as block start, and each following first-channel subframe fills the next bit position.

Capture goes into a shadow register. The host-visible copy is replaced in a single cycle, and only when a complete block of 192 first-channel subframes has arrived after a block start. Because of this, a read never returns a mix of two blocks. If a block start arrives before the block is complete, the partial block is discarded and capture starts again from that subframe. At each replacement the new block is compared with the copy it overwrites. If they differ, a change flag is raised, and the flag stays set until the host clears it with a write-one-to-clear strobe.

The subframe input is a valid/ready stream. The block never applies back-pressure: `in_ready` is held high from the first clock edge after reset is released, and a beat counts only in a cycle where `in_valid` and `in_ready` are both high. The read port and the clear strobe are plain control pins.

Top module: `cs_capture_buf`

## Requirements
- R1: After reset, `chg_irq` is 0 and every read address returns 0. `in_ready` is 1 from the first clock edge after reset is released.
- R2: `in_ready` stays high while the block is out of reset. A cycle with `in_valid` low has no effect, whatever `in_pre` and `in_cs` carry.
- R3: The `in_pre` code 2'b00 marks a first-channel subframe that starts a block, 2'b01 marks any other first-channel subframe, and 2'b10 or 2'b11 marks a second-channel subframe. Second-channel subframes are ignored.
- R4: Counting the block-start subframe as k = 0, the channel status bit of the k-th first-channel subframe of a block is read at byte address k/8, bit position k%8 of `rd_data`.
- R5: The host copy changes only on the edge that accepts the 192nd first-channel subframe counted from a block start. The new block is readable from the next cycle. Until then reads return the previous block.
- R6: A block start that arrives before 192 subframes have been counted discards the partial block and restarts the count at k = 0.
- R7: First-channel subframes coded 2'b01 that arrive after a block has completed, or before any block start, are ignored until the next block start.
- R8: Read addresses 24 to 31 return 0.
- R9: When a block is committed and differs in any bit from the host copy it replaces (all zeros after reset), `chg_irq` is set. Committing an identical block leaves `chg_irq` unchanged.
- R10: `chg_irq` stays set until a cycle with `clr_we`=1 and `clr_bit`=1, which clears it on that edge. `clr_bit`=0 has no effect. If a clear and a differing commit fall on the same edge, the flag ends up set.
- R11: `rd_data` follows `rd_addr` combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Subframe beat valid |
| in_ready | output | 1 | Beat accepted when high with in_valid |
| in_pre | input | 2 | Subframe type code (see R3) |
| in_cs | input | 1 | Channel status bit of the subframe |
| rd_addr | input | ADDR_W (5) | Host byte address |
| rd_data | output | 8 | Host read data |
| clr_we | input | 1 | Write strobe for the change flag |
| clr_bit | input | 1 | Write data; 1 clears the change flag |
| chg_irq | output | 1 | Channel status change flag |

## Verification
The assertions check on every cycle that the host copy holds still except on a commit edge, that the change flag rises only right after a commit, that the flag holds until a write of one clears it, that out-of-range addresses read zero, and that ready stays high. Only the bench scenarios can show where each bit lands in the byte map, that second-channel subframes and idle cycles are ignored, that an early block start discards the partial block, and that stray subframes after completion are ignored. The same holds for the choice between setting and leaving the flag depending on the block contents.

// File: rtl/cs_pkg.sv
package cs_pkg;
  // Subframe type code carried with every beat
  typedef enum logic [1:0] {
    SF_START = 2'b00,  // first channel, block start
    SF_CHA   = 2'b01,  // first channel
    SF_CHB   = 2'b10,  // second channel
    SF_CHB2  = 2'b11   // second channel, alternate code
  } sf_kind_e;
endpackage

// File: rtl/cs_frame_gate.sv
module cs_frame_gate
  import cs_pkg::*;
(
  input  logic       beat_ok,
  input  logic [1:0] kind,
  output logic       a_start,
  output logic       a_data
);
  sf_kind_e k;
  always_comb begin
    k       = sf_kind_e'(kind);
    a_start = beat_ok && (k == SF_START);
    a_data  = beat_ok && (k == SF_CHA);
  end
endmodule

// File: rtl/cs_shadow.sv
module cs_shadow #(
  parameter int BLK_BITS = 192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                a_start,
  input  logic                a_data,
  input  logic                cs_bit,
  output logic                commit,
  output logic [BLK_BITS-1:0] blk_next
);
  localparam int CNT_W = $clog2(BLK_BITS + 1);
  localparam int IDX_W = $clog2(BLK_BITS);

  logic                active_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [CNT_W-1:0]    cnt_nx;
  logic [BLK_BITS-1:0] shd_q;
  logic [IDX_W-1:0]    wr_idx;
  logic                wr_en;

  always_comb begin
    wr_en  = a_start || (a_data && active_q);
    wr_idx = a_start ? '0 : cnt_q[IDX_W-1:0];
    cnt_nx = a_start ? CNT_W'(1) : cnt_q + CNT_W'(1);
    commit = wr_en && (cnt_nx == CNT_W'(BLK_BITS));
    blk_next = shd_q;
    if (wr_en) blk_next[wr_idx] = cs_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      shd_q    <= '0;
    end else begin
      shd_q <= blk_next;
      if (commit) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else if (wr_en) begin
        active_q <= 1'b1;
        cnt_q    <= cnt_nx;
      end
    end
  end
endmodule

// File: rtl/cs_host_bank.sv
module cs_host_bank #(
  parameter int BLK_BITS = 192,
  parameter int ADDR_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                commit,
  input  logic [BLK_BITS-1:0] blk_in,
  input  logic                clr_we,
  input  logic                clr_bit,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [7:0]          rd_data,
  output logic                irq,
  output logic [BLK_BITS-1:0] host_q
);
  localparam int BYTES = BLK_BITS / 8;

  logic [7:0] byte_v [BYTES];
  logic       irq_q;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign byte_v[b] = host_q[b*8 +: 8];
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) < BYTES) rd_data = byte_v[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (commit) host_q <= blk_in;
      if (commit && (blk_in != host_q)) irq_q <= 1'b1;
      else if (clr_we && clr_bit)       irq_q <= 1'b0;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/cs_capture_buf.sv
module cs_capture_buf #(
  parameter int BLK_BITS = 192,
  parameter int ADDR_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_pre,
  input  logic              in_cs,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              clr_we,
  input  logic              clr_bit,
  output logic              chg_irq
);
  logic                ready_q;
  logic                a_start, a_data, commit;
  logic [BLK_BITS-1:0] blk_next, host_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign in_ready = ready_q;

  cs_frame_gate u_gate (
    .beat_ok (in_valid && ready_q),
    .kind    (in_pre),
    .a_start (a_start),
    .a_data  (a_data)
  );

  cs_shadow #(.BLK_BITS(BLK_BITS)) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_start  (a_start),
    .a_data   (a_data),
    .cs_bit   (in_cs),
    .commit   (commit),
    .blk_next (blk_next)
  );

  cs_host_bank #(.BLK_BITS(BLK_BITS), .ADDR_W(ADDR_W)) u_host (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (commit),
    .blk_in  (blk_next),
    .clr_we  (clr_we),
    .clr_bit (clr_bit),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .irq     (chg_irq),
    .host_q  (host_q)
  );
endmodule

// File: rtl/cs_capture_chk.sv
module cs_capture_chk #(
  parameter int BLK_BITS = 192,
  parameter int ADDR_W   = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_ready,
  input logic [ADDR_W-1:0]   rd_addr,
  input logic [7:0]          rd_data,
  input logic                clr_we,
  input logic                clr_bit,
  input logic                chg_irq,
  input logic                commit,
  input logic [BLK_BITS-1:0] host_q
);
  localparam int BYTES = BLK_BITS / 8;

  a_r2_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> in_ready);

  a_r5_host_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(host_q));

  a_r8_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_addr) >= BYTES) |-> (rd_data == 8'h00));

  a_r9_rise_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_irq) |-> $past(commit));

  a_r10_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_irq && !(clr_we && clr_bit)) |=> chg_irq);

  a_r10_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_bit && !commit) |=> !chg_irq);
endmodule

bind cs_capture_buf cs_capture_chk #(.BLK_BITS(BLK_BITS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_cs_capture_buf.sv
`timescale 1ns/1ps
module sim_cs_capture_buf;
  localparam int NB = 192;
  localparam logic [1:0] P_Z = 2'b00, P_X = 2'b01, P_Y = 2'b10, P_Y2 = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_cs = 1'b0, clr_we = 1'b0, clr_bit = 1'b0;
  logic [1:0] in_pre = 2'b00;
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic in_ready, chg_irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  bit mon_req = 0;

  always #5 clk = ~clk;

  cs_capture_buf u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pre(in_pre), .in_cs(in_cs), .rd_addr(rd_addr), .rd_data(rd_data),
    .clr_we(clr_we), .clr_bit(clr_bit), .chg_irq(chg_irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] pat(int seed);
    logic [NB-1:0] b;
    for (int k = 0; k < NB; k++) b[k] = (((k * seed) + (k >> 3) * 5 + seed) % 3) == 0;
    return b;
  endfunction

  task automatic beat(logic [1:0] pre, logic cs, logic clr);
    @(negedge clk);
    in_valid = 1'b1; in_pre = pre; in_cs = cs;
    clr_we = clr; clr_bit = clr;
    @(posedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0; in_pre = P_Z; in_cs = 1'b1; clr_we = 1'b0;
    end
  endtask

  // Driver: first-channel frames first..last of blk, each followed by a
  // second-channel frame with the inverted bit; idle cycles with junk (R2, R3).
  task automatic send(logic [NB-1:0] blk, int first, int last, bit clr_last);
    for (int k = first; k <= last; k++) begin
      if (k % 7 == 3) idle(1);
      beat((k == 0) ? P_Z : P_X, blk[k], clr_last && (k == last));
      beat((k % 2 == 0) ? P_Y : P_Y2, ~blk[k], 1'b0);
    end
    idle(1);
  endtask

  task automatic clr_pulse(logic b);
    @(negedge clk); clr_we = 1'b1; clr_bit = b;
    @(negedge clk); clr_we = 1'b0; clr_bit = 1'b0;
  endtask

  // Scoreboard hand-off: push expected bytes, the monitor reads and compares
  task automatic expect_host(logic [NB-1:0] blk);
    for (int i = 0; i < NB / 8; i++) exp_q.push_back(blk[i*8 +: 8]);
    mon_req = 1;
    wait (!mon_req);
  endtask

  initial begin : monitor
    forever begin
      wait (mon_req);
      for (int a = 0; a < NB / 8; a++) begin
        logic [7:0] e;
        @(negedge clk); rd_addr = 5'(a); #1;
        e = exp_q.pop_front();
        chk($sformatf("R4 R11 byte %0d", a), {24'h0, rd_data}, {24'h0, e});
      end
      mon_req = 0;
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin : main
    logic [NB-1:0] ba, bb, bc, bd;
    logic any;
    ba = pat(3); bb = pat(5); bc = pat(7); bd = pat(11);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 irq after reset", {31'h0, chg_irq}, 0);
    chk("R1 R2 ready after reset", {31'h0, in_ready}, 1);
    any = 1'b0;
    for (int a = 0; a < 32; a++) begin rd_addr = 5'(a); #1; any |= |rd_data; end
    chk("R1 all reads zero", {31'h0, any}, 0);

    // R5: 191 frames leave the host copy untouched
    send(ba, 0, 190, 1'b0);
    rd_addr = 5'd23; #1;
    chk("R5 host unchanged before 192nd frame", {24'h0, rd_data}, 0);
    chk("R5 no flag before commit", {31'h0, chg_irq}, 0);
    send(ba, 191, 191, 1'b0);
    chk("R9 flag on differing block", {31'h0, chg_irq}, 1);
    expect_host(ba);

    // R8 out-of-range addresses
    any = 1'b0;
    for (int a = 24; a < 32; a++) begin rd_addr = 5'(a); #1; any |= |rd_data; end
    chk("R8 addresses 24-31 read zero", {31'h0, any}, 0);

    // R10 write-one-to-clear
    clr_pulse(1'b0);
    chk("R10 clr_bit 0 no effect", {31'h0, chg_irq}, 1);
    clr_pulse(1'b1);
    chk("R10 clr_bit 1 clears", {31'h0, chg_irq}, 0);

    // R9 identical block leaves flag clear
    send(ba, 0, 191, 1'b0);
    chk("R9 identical block no flag", {31'h0, chg_irq}, 0);
    expect_host(ba);

    // R6 early block start discards partial block
    send(bb, 0, 99, 1'b0);
    chk("R6 partial not committed", {31'h0, chg_irq}, 0);
    send(bc, 0, 191, 1'b0);
    chk("R6 restarted block committed", {31'h0, chg_irq}, 1);
    expect_host(bc);

    // R7 stray first-channel frames after completion are ignored
    clr_pulse(1'b1);
    send(bd, 5, 54, 1'b0);
    chk("R7 stray frames no flag", {31'h0, chg_irq}, 0);
    expect_host(bc);

    // R10 set wins over clear on the same edge
    send(bd, 0, 191, 1'b1);
    chk("R10 set wins over clear", {31'h0, chg_irq}, 1);
    expect_host(bd);

    idle(2);
    summary();
  end
endmodule